// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic and Logic Unit with Byte Multiply and Sign/Zero Flags

This block is the purely combinational execution stage of a small single-cycle processor core. It takes a destination operand, a source operand and a 4-bit operation code. In the same cycle it returns a 16-bit result together with a sign flag and a zero flag. The caller writes the result and the flags back into its register file. The conditional branches use only those two flags, so no carry or overflow indication exists anywhere on the block.

Immediate instructions use the same datapath. When the immediate select is high, an 8-bit constant is zero-extended and replaces the source operand for every operation. Single-operand operations (move, shifts, rotates, byte swap) always act on the source operand. The multiplier takes the low byte of each operand and returns the full 16-bit product. Its internal form is chosen by a parameter: a plain product operator, or an unrolled shift-and-add array.

Top module: `alu16_core`

## Requirements
- R1: With operation code 0 (move), the result equals the source operand.
- R2: Operation codes 1, 2 and 3 give the bitwise AND, OR and XOR of the destination and source operands.
- R3: Operation code 4 gives destination plus source modulo 2^16. The carry out of bit 15 is discarded and appears on no output.
- R4: Operation code 5 gives destination minus source modulo 2^16.
- R5: Operation code 6 shifts the source left by one place and fills bit 0 with zero. Operation code 7 shifts it right by one place and fills bit 15 with zero, which halves an unsigned value.
- R6: Operation code 8 rotates the source left by one place, so bit 15 moves into bit 0. Operation code 9 rotates it right by one place, so bit 0 moves into bit 15.
- R7: Operation code 10 exchanges the upper byte (bits 15:8) and the lower byte (bits 7:0) of the source.
- R8: Operation code 11 multiplies bits 7:0 of the destination by bits 7:0 of the source as unsigned numbers and returns the full 16-bit product.
- R9: For every operation code, the sign flag equals result bit 15, and the zero flag is 1 exactly when all 16 result bits are 0.
- R10: When the immediate select is 1, the source operand is replaced by the 8-bit immediate with bits 15:8 cleared, and the source operand input has no effect on the result.
- R11: Operation codes 12 to 15 are unassigned and give a result of zero, with the zero flag set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code |
| dst_opnd | input | 16 | Destination register operand (left-hand side) |
| src_opnd | input | 16 | Source register operand |
| imm_sel | input | 1 | 1 selects the zero-extended immediate as the source |
| imm_byte | input | 8 | Immediate constant |
| result | output | 16 | Operation result |
| sign_flag | output | 1 | Copy of result bit 15 |
| zero_flag | output | 1 | 1 when the result is all zeros |

## Verification
The embedded checks are immediate assertions that are evaluated whenever the combinational logic settles. They assume that the operation code and all operand inputs are driven to known 0/1 values and are never left unknown. The bench applies every stimulus at a clock edge and reads the outputs only at the following opposite edge. During its reset phase it holds every input at zero, so no check ever sees an undriven or partly settled value.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   localparam int OPC_W = 4;

   typedef enum logic [OPC_W-1:0] {
      OPC_MOVE = 4'd0,
      OPC_AND  = 4'd1,
      OPC_OR   = 4'd2,
      OPC_XOR  = 4'd3,
      OPC_ADD  = 4'd4,
      OPC_SUB  = 4'd5,
      OPC_SHL  = 4'd6,
      OPC_SHR  = 4'd7,
      OPC_ROL  = 4'd8,
      OPC_ROR  = 4'd9,
      OPC_SWAP = 4'd10,
      OPC_MUL  = 4'd11
   } alu_opc_e;

   function automatic logic opc_valid(input logic [OPC_W-1:0] code);
      return (code <= OPC_MUL);
   endfunction

endpackage

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
   import alu16_pkg::*;
#(
   parameter int DW = 16
) (
   input  alu_opc_e        opc,
   input  logic [DW-1:0]   lhs,
   input  logic [DW-1:0]   rhs,
   output logic [DW-1:0]   res
);
   localparam int HALF = DW / 2;

   logic [DW-1:0] swapped;

   // byte exchange built per lane
   for (genvar g = 0; g < HALF; g++) begin : g_swap
      assign swapped[g]        = rhs[g + HALF];
      assign swapped[g + HALF] = rhs[g];
   end

   always_comb begin
      unique case (opc)
         OPC_AND:  res = lhs & rhs;
         OPC_OR:   res = lhs | rhs;
         OPC_XOR:  res = lhs ^ rhs;
         OPC_SWAP: res = swapped;
         default:  res = rhs;
      endcase
   end

   // R7: the two halves trade places
   always_comb begin
      if (opc == OPC_SWAP) begin
         a_r7_halves_traded: assert ({res[HALF-1:0], res[DW-1:HALF]} == rhs)
            else $error("swap halves mismatch");
      end
   end

endmodule

// File: rtl/alu16_addsub.sv
module alu16_addsub #(
   parameter int DW = 16
) (
   input  logic            do_sub,
   input  logic [DW-1:0]   lhs,
   input  logic [DW-1:0]   rhs,
   output logic [DW-1:0]   res
);
   logic [DW-1:0] rhs_mod;
   logic [DW:0]   wide_sum;

   assign rhs_mod  = do_sub ? ~rhs : rhs;
   assign wide_sum = {1'b0, lhs} + {1'b0, rhs_mod} + {{DW{1'b0}}, do_sub};
   // top bit of the sum is the carry, dropped by design
   assign res      = wide_sum[DW-1:0];

   // R3 / R4: inverse relations of the adder
   always_comb begin
      if (do_sub) begin
         a_r4_sub_inverse: assert (DW'(res + rhs) == lhs)
            else $error("difference does not restore minuend");
      end else begin
         a_r3_add_inverse: assert (DW'(res - rhs) == lhs)
            else $error("sum does not restore addend");
      end
   end

endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter #(
   parameter int DW = 16
) (
   input  logic            go_left,
   input  logic            wrap,
   input  logic [DW-1:0]   src,
   output logic [DW-1:0]   res
);
   logic fill_lo;
   logic fill_hi;

   assign fill_lo = wrap & src[DW-1];
   assign fill_hi = wrap & src[0];

   always_comb begin
      if (go_left) res = {src[DW-2:0], fill_lo};
      else         res = {fill_hi, src[DW-1:1]};
   end

   // R5 / R6: edge bits of the moved word
   always_comb begin
      if (go_left) begin
         a_r6_left_edge: assert (res[0] == (wrap ? src[DW-1] : 1'b0))
            else $error("left shift fill bit wrong");
      end else begin
         a_r5_right_edge: assert (res[DW-1] == (wrap ? src[0] : 1'b0))
            else $error("right shift fill bit wrong");
      end
   end

endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
   parameter int MW    = 8,
   parameter int STYLE = 0
) (
   input  logic [MW-1:0]     x,
   input  logic [MW-1:0]     y,
   output logic [2*MW-1:0]   prod
);
   localparam int PW = 2 * MW;

   if (STYLE == 0) begin : g_operator
      assign prod = PW'(x) * PW'(y);
   end else begin : g_array
      logic [PW-1:0] partial [MW];
      for (genvar i = 0; i < MW; i++) begin : g_row
         assign partial[i] = y[i] ? (PW'(x) << i) : '0;
      end
      always_comb begin
         prod = '0;
         for (int i = 0; i < MW; i++) prod = prod + partial[i];
      end
   end

   // R8: product parity and zero factors
   always_comb begin
      a_r8_low_bit: assert (prod[0] == (x[0] & y[0]))
         else $error("product bit 0 wrong");
      if (x == '0 || y == '0) begin
         a_r8_zero_factor: assert (prod == '0)
            else $error("zero factor gave nonzero product");
      end
   end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
   import alu16_pkg::*;
#(
   parameter int DW        = 16,
   parameter int IMM_W     = 8,
   parameter int MUL_STYLE = 0
) (
   input  logic [OPC_W-1:0]  op_sel,
   input  logic [DW-1:0]     dst_opnd,
   input  logic [DW-1:0]     src_opnd,
   input  logic              imm_sel,
   input  logic [IMM_W-1:0]  imm_byte,
   output logic [DW-1:0]     result,
   output logic              sign_flag,
   output logic              zero_flag
);
   localparam int MW = DW / 2;

   if (DW % 2 != 0 || DW < 4) begin : g_bad_width
      $error("DW must be even and at least 4");
   end
   if (IMM_W > DW) begin : g_bad_imm
      $error("IMM_W must not exceed DW");
   end
   if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
      $error("MUL_STYLE must be 0 or 1");
   end

   alu_opc_e      opc;
   logic [DW-1:0] rhs;
   logic [DW-1:0] bit_res;
   logic [DW-1:0] as_res;
   logic [DW-1:0] sh_res;
   logic [DW-1:0] mul_res;
   logic          is_sub;
   logic          sh_left;
   logic          sh_wrap;

   assign opc = alu_opc_e'(op_sel);
   assign rhs = imm_sel ? DW'(imm_byte) : src_opnd;

   assign is_sub  = (opc == OPC_SUB);
   assign sh_left = (opc == OPC_SHL) || (opc == OPC_ROL);
   assign sh_wrap = (opc == OPC_ROL) || (opc == OPC_ROR);

   alu16_bitwise #(.DW(DW)) u_bitwise (
      .opc (opc),
      .lhs (dst_opnd),
      .rhs (rhs),
      .res (bit_res)
   );

   alu16_addsub #(.DW(DW)) u_addsub (
      .do_sub (is_sub),
      .lhs    (dst_opnd),
      .rhs    (rhs),
      .res    (as_res)
   );

   alu16_shifter #(.DW(DW)) u_shifter (
      .go_left (sh_left),
      .wrap    (sh_wrap),
      .src     (rhs),
      .res     (sh_res)
   );

   alu16_mul #(.MW(MW), .STYLE(MUL_STYLE)) u_mul (
      .x    (dst_opnd[MW-1:0]),
      .y    (rhs[MW-1:0]),
      .prod (mul_res)
   );

   always_comb begin
      if (!opc_valid(op_sel)) begin
         result = '0;
      end else begin
         unique case (opc)
            OPC_ADD, OPC_SUB:                  result = as_res;
            OPC_SHL, OPC_SHR, OPC_ROL, OPC_ROR: result = sh_res;
            OPC_MUL:                           result = mul_res;
            default:                           result = bit_res;
         endcase
      end
   end

   assign sign_flag = result[DW-1];
   assign zero_flag = ~|result;

   always_comb begin
      // R9: flags agree with the result count of ones
      a_r9_zero_flag: assert (zero_flag == ($countones(result) == 0))
         else $error("zero flag disagrees with result");
      // R1: move forwards the selected source unchanged
      if (op_sel == 4'd0) begin
         a_r1_move_copy: assert (result == rhs && sign_flag == rhs[DW-1])
            else $error("move did not copy source");
      end
      // R11: unassigned codes clear the result
      if (op_sel > 4'd11) begin
         a_r11_unassigned_zero: assert (zero_flag && !sign_flag)
            else $error("unassigned code gave nonzero result");
      end
      // R10: immediate upper bits cannot reach a bitwise AND
      if (imm_sel && op_sel == 4'd1) begin
         a_r10_imm_upper_clear: assert (result[DW-1:IMM_W] == '0)
            else $error("immediate upper bits leaked");
      end
   end

endmodule

// File: tb/alu16_core_bench.sv
module alu16_core_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_sel = '0;
   logic [15:0] dst_opnd = '0;
   logic [15:0] src_opnd = '0;
   logic        imm_sel = 1'b0;
   logic [7:0]  imm_byte = '0;
   logic [15:0] result;
   logic        sign_flag;
   logic        zero_flag;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   alu16_core u_alu16_core (
      .op_sel    (op_sel),
      .dst_opnd  (dst_opnd),
      .src_opnd  (src_opnd),
      .imm_sel   (imm_sel),
      .imm_byte  (imm_byte),
      .result    (result),
      .sign_flag (sign_flag),
      .zero_flag (zero_flag)
   );

   // {opcode, destination, source, expected result}
   localparam int NV = 16;
   localparam logic [51:0] VEC [NV] = '{
      {4'd0,  16'h1234, 16'hA5F0, 16'hA5F0},  // R1
      {4'd1,  16'hF0F0, 16'hFF00, 16'hF000},  // R2
      {4'd2,  16'hF0F0, 16'h0F0F, 16'hFFFF},  // R2
      {4'd3,  16'hFFFF, 16'h1234, 16'hEDCB},  // R2
      {4'd4,  16'h7FFF, 16'h0001, 16'h8000},  // R3
      {4'd4,  16'hFFFF, 16'h0002, 16'h0001},  // R3 carry dropped
      {4'd5,  16'h0005, 16'h0007, 16'hFFFE},  // R4 wrap
      {4'd5,  16'h1234, 16'h1234, 16'h0000},  // R4
      {4'd6,  16'h0000, 16'h8001, 16'h0002},  // R5
      {4'd7,  16'h0000, 16'h8001, 16'h4000},  // R5
      {4'd7,  16'h0000, 16'h0064, 16'h0032},  // R5 halving
      {4'd8,  16'h0000, 16'h8001, 16'h0003},  // R6
      {4'd9,  16'h0000, 16'h8001, 16'hC000},  // R6
      {4'd10, 16'h0000, 16'h12AB, 16'hAB12},  // R7
      {4'd11, 16'hFFFF, 16'h00FF, 16'hFE01},  // R8
      {4'd11, 16'h3412, 16'h5610, 16'h0120}   // R8 upper bytes ignored
   };

   function automatic string req_of(input logic [3:0] code);
      case (code)
         4'd0:                    return "R1";
         4'd1, 4'd2, 4'd3:        return "R2";
         4'd4:                    return "R3";
         4'd5:                    return "R4";
         4'd6, 4'd7:              return "R5";
         4'd8, 4'd9:              return "R6";
         4'd10:                   return "R7";
         4'd11:                   return "R8";
         default:                 return "R11";
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_flags(input logic [15:0] exp);
      check("R9 sign", {15'd0, sign_flag}, {15'd0, exp[15]});
      check("R9 zero", {15'd0, zero_flag}, {15'd0, (exp == 16'h0000)});
   endtask

   task automatic apply(input logic [3:0] c, input logic [15:0] d, input logic [15:0] s,
                        input logic im, input logic [7:0] ib);
      @(posedge clk);
      op_sel   <= c;
      dst_opnd <= d;
      src_opnd <= s;
      imm_sel  <= im;
      imm_byte <= ib;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // reset state: all inputs zero means move of zero
      check("R1 reset", result, 16'h0000);
      check("R9 reset zero", {15'd0, zero_flag}, 16'h0001);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][51:48], VEC[i][47:32], VEC[i][31:16], 1'b0, 8'h00);
         check(req_of(VEC[i][51:48]), result, VEC[i][15:0]);
         check_flags(VEC[i][15:0]);
      end

      // R10: immediate replaces source, source input ignored
      apply(4'd4, 16'h0100, 16'hFFFF, 1'b1, 8'h80);
      check("R10 add imm", result, 16'h0180);
      apply(4'd4, 16'h0100, 16'h0000, 1'b1, 8'h80);
      check("R10 src ignored", result, 16'h0180);
      apply(4'd1, 16'hFFFF, 16'hFFFF, 1'b1, 8'h3C);
      check("R10 zero extend", result, 16'h003C);
      apply(4'd0, 16'h0000, 16'h1234, 1'b1, 8'hF0);
      check("R10 move imm", result, 16'h00F0);
      check_flags(16'h00F0);

      // R11: every unassigned code
      for (int c = 12; c < 16; c++) begin
         apply(4'(c), 16'hFFFF, 16'hFFFF, 1'b0, 8'h00);
         check("R11 result", result, 16'h0000);
         check("R11 zero", {15'd0, zero_flag}, 16'h0001);
      end

      // R9: negative result sets sign, clears zero
      apply(4'd5, 16'h0000, 16'h0001, 1'b0, 8'h00);
      check("R4 neg", result, 16'hFFFF);
      check_flags(16'hFFFF);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      for (int n = 0; n < 20000; n++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule